// File: doc/BRIEF.md
# Six-Channel Compare Timer

This block is a memory-mapped timer with six independent 32-bit up-counters. Each counter has a compare register. When the counter reaches the compare value, the channel raises a pending flag. A per-channel mode field decides what happens after a match: the channel can stop (one-shot), restart from zero (auto-reload), or keep counting (free-run). Each channel chooses its tick source, either a fast system tick or a slow real-time tick, and can divide the chosen tick by a small programmable factor.

Software reaches the block over a simple 32-bit register bus. The bus has a word address, a write strobe and combinational read data, so a read returns the value of the currently addressed register in the same cycle. There is no handshake: every write is taken in the cycle its strobe is high.

One shared register holds an interrupt-enable bit for every channel. A second shared register holds the pending flags; writing a 1 to a bit of it clears that flag. A single interrupt line reports any pending channel whose enable bit is set. The tick inputs are enable pulses that are synchronous to the block clock.

Top module: `cmp_timer_unit`

## Requirements
- R1: Register map, with byte offsets equal to 4 × word address. Channel n (1..6) has its control register at 0x10·n, its clock register at 0x04+0x10·n, its counter at 0x08+0x10·n and its compare register at 0x0C+0x10·n. The interrupt-enable register is at 0x00 and the pending/acknowledge register is at 0x08. Bit n-1 of each shared register belongs to channel n. Reads of 0x04, 0x0C and of word addresses 28 to 31 return 0, and writes to them are ignored.
- R2: While its control bit 0 (enable) is 1 and no clear is in progress, a channel adds 1 to its counter on each divided tick. While enable is 0, the counter holds its value.
- R3: Clock register bit 4 selects the tick source: 0 is the system tick and 1 is the real-time tick. Bits [3:0] hold D, and the counter advances once every D+1 selected ticks. The divider counts only while the channel is running.
- R4: Mode is control bits [5:4]. In mode 0 (one-shot), a tick that takes the counter to the compare value sets the pending flag and clears the enable bit. The counter is then left at the compare value.
- R5: In mode 1 (auto-reload), a tick that would take the counter to the compare value sets the pending flag and loads the counter with 0 instead. The period is therefore the compare value, measured in divided ticks.
- R6: In mode 3 (free-run), and in the reserved mode 2, a match only sets the pending flag. The counter wraps from 0xFFFFFFFF to 0.
- R7: Writing control bit 1 (clear) zeroes the counter and the divider at that write. The bit then reads 1 for exactly one cycle. During that cycle the counter is held at 0 and writes to the counter are ignored, and counting resumes after it.
- R8: Writing 1 to bit n-1 of the acknowledge register clears channel n's pending flag, and writing 0x3f clears all six. Reading this register returns the pending flags. If a match and an acknowledge of the same channel fall in the same cycle, the flag stays set.
- R9: A pending flag is set whatever the enable bits hold. The interrupt output is high exactly when some channel has both its pending flag and its enable bit set.
- R10: Writing the counter register loads the written value, and this takes priority over a tick in the same cycle. A loaded value never counts as a match.
- R11: After reset every register reads 0 (every channel is in one-shot mode and stopped), and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | Fast tick enable, one clock wide per tick |
| rtc_tick | input | 1 | Slow real-time tick enable |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 1 | Interrupt: OR of pending AND enabled |

## Verification
The assertions check the following properties on every cycle:
- A clear holds the counter at zero.
- A one-shot match drops the enable bit.
- An auto-reload match returns the counter to zero.
- Free-run keeps the channel enabled.
- A stopped counter stays stable.
- An acknowledge clears only flags that are not being set in the same cycle.
- New matches always latch.

The bench's scenarios are what show the counting sequences themselves: match timing against the compare value, wrap at 2^32, tick-source selection and division, and the register map. They also exercise the same-cycle collisions (clear against counter load, match against acknowledge) through a cycle-accurate model driven by random writes and random ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_RELOAD = 2'd1,
    MODE_RSVD   = 2'd2,
    MODE_FREE   = 2'd3
  } tmr_mode_e;

  // word index inside a channel bank
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CLK  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CMP  = 2'd3;

  // word index inside the shared bank
  localparam logic [1:0] REG_IEN  = 2'd0;
  localparam logic [1:0] REG_PEND = 2'd2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CLK_SRC_BIT   = 4;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sys_tick,
  input  logic            rtc_tick,
  input  logic            src_rtc,
  input  logic [DIVW-1:0] div,
  input  logic            run,
  input  logic            restart,
  output logic            step
);

  logic [DIVW-1:0] pre_q;
  logic            tick;

  assign tick = src_rtc ? rtc_tick : sys_tick;
  assign step = run && tick && (pre_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (run && tick) begin
      pre_q <= step ? '0 : pre_q + 1'b1;
    end
  end

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0)); // R7

  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(pre_q)); // R3

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW   = 32,
  parameter int DIVW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_tick,
  input  logic          rtc_tick,
  input  logic          wr_en,
  input  logic [1:0]    reg_idx,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          match
);

  logic            en_q;
  logic            clr_q;
  logic            src_q;
  tmr_mode_e       mode_q;
  logic [DIVW-1:0] div_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cmp_q;
  logic [CW-1:0]   cnt_inc;

  logic wr_ctrl, wr_clk, wr_cnt, wr_cmp;
  logic clr_now, run, step;

  assign wr_ctrl = wr_en && (reg_idx == REG_CTRL);
  assign wr_clk  = wr_en && (reg_idx == REG_CLK);
  assign wr_cnt  = wr_en && (reg_idx == REG_CNT);
  assign wr_cmp  = wr_en && (reg_idx == REG_CMP);

  assign clr_now = wr_ctrl && wdata[CTRL_CLR_BIT];
  assign run     = en_q && !clr_q;

  tmr_prescale #(.DIVW(DIVW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_tick (sys_tick),
    .rtc_tick (rtc_tick),
    .src_rtc  (src_q),
    .div      (div_q),
    .run      (run),
    .restart  (clr_now || clr_q),
    .step     (step)
  );

  assign cnt_inc = cnt_q + 1'b1;
  assign match   = step && !clr_now && !wr_cnt && (cnt_inc == cmp_q);

  // counter: clear beats load, load beats counting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_now || clr_q) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata;
    end else if (step) begin
      cnt_q <= (match && (mode_q == MODE_RELOAD)) ? '0 : cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      clr_q  <= 1'b0;
      mode_q <= MODE_ONCE;
    end else if (wr_ctrl) begin
      en_q   <= wdata[CTRL_EN_BIT];
      clr_q  <= wdata[CTRL_CLR_BIT];
      mode_q <= tmr_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
    end else begin
      clr_q <= 1'b0;
      if (match && (mode_q == MODE_ONCE)) en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      div_q <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_clk) begin
        src_q <= wdata[CLK_SRC_BIT];
        div_q <= wdata[DIVW-1:0];
      end
      if (wr_cmp) cmp_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_idx)
      REG_CTRL: begin
        rdata[CTRL_EN_BIT]            = en_q;
        rdata[CTRL_CLR_BIT]           = clr_q;
        rdata[CTRL_MODE_LSB +: 2]     = mode_q;
      end
      REG_CLK: begin
        rdata[DIVW-1:0]               = div_q;
        rdata[CLK_SRC_BIT]            = src_q;
      end
      REG_CNT: rdata = cnt_q;
      default: rdata = cmp_q;
    endcase
  end

  AST_CLR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (cnt_q == '0)); // R7

  AST_ONCE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (match && (mode_q == MODE_ONCE) && !wr_ctrl) |=> !en_q); // R4

  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (match && (mode_q == MODE_RELOAD)) |=> (cnt_q == '0)); // R5

  AST_FREE_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode_q[1] && !wr_ctrl) |=> en_q); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr_q && !clr_now && !wr_cnt) |=> $stable(cnt_q)); // R2

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !clr_now && !clr_q) |=> (cnt_q == $past(wdata))); // R10

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ien,
  input  logic           wr_ack,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] set,
  output logic [NCH-1:0] ien,
  output logic [NCH-1:0] pend,
  output logic           irq
);

  logic [NCH-1:0] ack_mask;

  assign ack_mask = wr_ack ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= '0;
      pend <= '0;
    end else begin
      if (wr_ien) ien <= wdata;
      pend <= (pend & ~ack_mask) | set;
    end
  end

  assign irq = |(pend & ien);

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((pend & $past(wdata & ~set)) == '0)); // R8

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((pend & $past(set)) == $past(set))); // R9

endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import tmr_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int CW   = 32,
  parameter int DIVW = 4,
  parameter int AW   = $clog2(4 * (NCH + 1))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_tick,
  input  logic          rtc_tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);

  localparam int BW = AW - 2;

  logic [BW-1:0]  bank;
  logic [1:0]     idx;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] ien;
  logic [NCH-1:0] pend;
  logic [CW-1:0]  ch_rd [NCH];
  logic           shared_sel;

  assign bank       = bus_addr[AW-1:2];
  assign idx        = bus_addr[1:0];
  assign shared_sel = (bank == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = (32'(bank) == c + 1);

    tmr_channel #(.CW(CW), .DIVW(DIVW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .sys_tick (sys_tick),
      .rtc_tick (rtc_tick),
      .wr_en    (bus_wr && sel),
      .reg_idx  (idx),
      .wdata    (bus_wdata),
      .rdata    (ch_rd[c]),
      .match    (hit[c])
    );
  end

  tmr_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ien (bus_wr && shared_sel && (idx == REG_IEN)),
    .wr_ack (bus_wr && shared_sel && (idx == REG_PEND)),
    .wdata  (bus_wdata[NCH-1:0]),
    .set    (hit),
    .ien    (ien),
    .pend   (pend),
    .irq    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (shared_sel) begin
      if (idx == REG_IEN)  bus_rdata[NCH-1:0] = ien;
      if (idx == REG_PEND) bus_rdata[NCH-1:0] = pend;
    end
    for (int c = 0; c < NCH; c++) begin
      if (32'(bank) == c + 1) bus_rdata = ch_rd[c];
    end
  end

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (pend != '0)); // R9

endmodule

// File: tb/test_cmp_timer_unit.sv
module test_cmp_timer_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_tick = 1'b0;
  logic        rtc_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer_unit i_cmp_timer_unit (
    .clk (clk), .rst_n (rst_n), .sys_tick (sys_tick), .rtc_tick (rtc_tick),
    .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .irq (irq)
  );

  // ---------------- reference model from the requirements ----------------
  logic [31:0] m_cnt [6];
  logic [31:0] m_cmp [6];
  logic        m_en  [6];
  logic        m_clr [6];
  logic [1:0]  m_mode[6];
  logic        m_src [6];
  logic [3:0]  m_div [6];
  logic [3:0]  m_pre [6];
  logic [5:0]  m_pend, m_ien;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 6; c++) begin
        m_cnt[c] = '0; m_cmp[c] = '0; m_en[c] = 1'b0; m_clr[c] = 1'b0;
        m_mode[c] = '0; m_src[c] = 1'b0; m_div[c] = '0; m_pre[c] = '0;
      end
      m_pend = '0; m_ien = '0;
    end else begin
      logic [5:0] setv;
      setv = '0;
      for (int c = 0; c < 6; c++) begin
        logic w, wc, wk, wn, wm, clrw, tk, run, stp, hit;
        logic [31:0] nx;
        w    = bus_wr && (int'(bus_addr[4:2]) == c + 1);
        wc   = w && (bus_addr[1:0] == 2'd0);
        wk   = w && (bus_addr[1:0] == 2'd1);
        wn   = w && (bus_addr[1:0] == 2'd2);
        wm   = w && (bus_addr[1:0] == 2'd3);
        clrw = wc && bus_wdata[1];
        tk   = m_src[c] ? rtc_tick : sys_tick;
        run  = m_en[c] && !m_clr[c];
        stp  = run && tk && (m_pre[c] >= m_div[c]);
        hit  = 1'b0;
        nx   = m_cnt[c] + 32'd1;
        if (clrw || m_clr[c]) m_cnt[c] = '0;
        else if (wn) m_cnt[c] = bus_wdata;
        else if (stp) begin
          if (nx == m_cmp[c]) begin
            hit = 1'b1;
            m_cnt[c] = (m_mode[c] == 2'd1) ? 32'd0 : nx;
          end else m_cnt[c] = nx;
        end
        if (clrw || m_clr[c]) m_pre[c] = '0;
        else if (run && tk) m_pre[c] = stp ? 4'd0 : m_pre[c] + 4'd1;
        if (wc) begin
          m_en[c] = bus_wdata[0]; m_clr[c] = bus_wdata[1]; m_mode[c] = bus_wdata[5:4];
        end else begin
          m_clr[c] = 1'b0;
          if (hit && m_mode[c] == 2'd0) m_en[c] = 1'b0;
        end
        if (wk) begin m_src[c] = bus_wdata[4]; m_div[c] = bus_wdata[3:0]; end
        if (wm) m_cmp[c] = bus_wdata;
        setv[c] = hit;
      end
      if (bus_wr && bus_addr == 5'd2) m_pend = m_pend & ~bus_wdata[5:0];
      m_pend = m_pend | setv;
      if (bus_wr && bus_addr == 5'd0) m_ien = bus_wdata[5:0];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    int b;
    b = int'(a[4:2]);
    if (b == 0) begin
      if (a[1:0] == 2'd0) return {26'd0, m_ien};
      if (a[1:0] == 2'd2) return {26'd0, m_pend};
      return 32'd0;
    end
    if (b > 6) return 32'd0;
    case (a[1:0])
      2'd0:    return {26'd0, m_mode[b-1], 2'b00, m_clr[b-1], m_en[b-1]};
      2'd1:    return {27'd0, m_src[b-1], m_div[b-1]};
      2'd2:    return m_cnt[b-1];
      default: return m_cmp[b-1];
    endcase
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R11 reset state
    chk(5'd0, 32'd0, "R11 ien");
    chk(5'd2, 32'd0, "R11 pend");
    chk(5'd4, 32'd0, "R11 ctrl");
    chk(5'd6, 32'd0, "R11 cnt");
    check("R11 irq", {31'd0, irq}, 32'd0);

    // free-run on channel 1, compare 5
    sys_tick = 1'b1;
    wr(5'd7, 32'd5);
    wr(5'd4, 32'h33);
    chk(5'd4, 32'h33, "R7 clear bit visible");
    chk(5'd6, 32'd0, "R7 counter zero");
    idle(1);
    chk(5'd4, 32'h31, "R7 clear bit self-clears");
    chk(5'd6, 32'd0, "R7 held during clear");
    idle(3);
    chk(5'd6, 32'd3, "R2 counts per tick");
    idle(2);
    chk(5'd2, 32'd1, "R6 match pends");
    chk(5'd6, 32'd5, "R6 keeps counting value");
    check("R9 masked irq", {31'd0, irq}, 32'd0);
    wr(5'd0, 32'd1);
    check("R9 enabled irq", {31'd0, irq}, 32'd1);
    wr(5'd2, 32'd1);
    chk(5'd2, 32'd0, "R8 ack clears");
    check("R8 irq drops", {31'd0, irq}, 32'd0);
    wr(5'd6, 32'hFFFF_FFFF);
    chk(5'd6, 32'hFFFF_FFFF, "R10 load");
    idle(1);
    chk(5'd6, 32'd0, "R6 wrap");
    wr(5'd4, 32'h30);
    idle(3);
    chk(5'd6, 32'd1, "R2 hold when disabled");
    chk(5'd4, 32'h30, "R2 ctrl readback");

    // one-shot
    wr(5'd4, 32'h03);
    idle(6);
    chk(5'd6, 32'd5, "R4 stops at compare");
    chk(5'd4, 32'h00, "R4 enable cleared");
    chk(5'd2, 32'd1, "R4 pending");
    idle(2);
    chk(5'd6, 32'd5, "R4 stays stopped");
    wr(5'd2, 32'h3f);
    chk(5'd2, 32'd0, "R8 ack all");

    // auto-reload
    wr(5'd4, 32'h13);
    idle(6);
    chk(5'd6, 32'd0, "R5 reload to zero");
    chk(5'd2, 32'd1, "R5 pending");
    chk(5'd4, 32'h11, "R5 still enabled");
    idle(1);
    chk(5'd6, 32'd1, "R5 restarts");
    idle(4);
    chk(5'd6, 32'd0, "R5 second period");
    wr(5'd4, 32'h0);
    wr(5'd2, 32'h3f);

    // channel 2 on real-time tick, divide by 2
    wr(5'd9, 32'h11);
    wr(5'd8, 32'h33);
    idle(4);
    chk(5'd10, 32'd0, "R3 ignores system tick");
    chk(5'd9, 32'h11, "R3 clock readback");
    rtc_tick = 1'b1;
    idle(4);
    rtc_tick = 1'b0;
    chk(5'd10, 32'd2, "R3 divide by two");
    wr(5'd8, 32'h0);

    // map corners
    chk(5'd1, 32'd0, "R1 hole at 0x04");
    chk(5'd3, 32'd0, "R1 hole at 0x0C");
    wr(5'd29, 32'hFFFF);
    chk(5'd29, 32'd0, "R1 unmapped word");
    wr(5'd27, 32'hABCD);
    chk(5'd27, 32'hABCD, "R1 channel 6 compare");
    chk(5'd23, 32'd0, "R1 channel 5 compare untouched");

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] a;
      logic [31:0] d;
      sys_tick = ($urandom % 4) != 0;
      rtc_tick = ($urandom % 8) == 0;
      a = 5'($urandom % 32);
      case (a[1:0])
        2'd0:    d = (a[4:2] == 3'd0) ? 32'($urandom % 64)
                     : {26'd0, 2'($urandom % 4), 2'b00, 1'(($urandom % 6) == 0), 1'(($urandom % 4) != 0)};
        2'd1:    d = {27'd0, 1'($urandom % 2), 4'($urandom % 4)};
        2'd2:    d = (a[4:2] == 3'd0) ? 32'($urandom % 64)
                     : (($urandom % 2) != 0) ? 32'($urandom % 8) : 32'hFFFF_FFF8 + 32'($urandom % 8);
        default: d = 32'd1 + 32'($urandom % 10);
      endcase
      bus_wr = ($urandom % 4) == 0;
      bus_wdata = d;
      bus_addr = a;
      #1;
      check("R1 random readback", bus_rdata, exp_rd(a));
      check("R9 random irq", {31'd0, irq}, {31'd0, |(m_pend & m_ien)});
      @(negedge clk);
    end
    bus_wr = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule